// File: doc/BRIEF.md
# Serial Configuration Register Slave for a Clock Generator

This block is the configuration port of a clock generator. It listens on a two-wire serial bus as a receive-and-readback slave, holds a small bank of 8-bit registers, and presents them to the clock distribution logic. Those registers carry the per-output clock enables and the function select. Both bus lines are oversampled by the system clock through synchronizers. The slave answers on SDA only by asserting a pull-down enable, and a pad outside this block turns that enable into the open-drain driver.

The port has no register pointer. A write names the device, then sends two bytes that are acknowledged and thrown away, then sends data bytes. These fill register 0, register 1 and onward until the master issues STOP or a new START. A read names the device and then streams the bank out, starting at register 0. A pin-level output enable overrides the function select and can force every clock output into the high-impedance state.

Top module: `clkcfg_serial_slave`

## Requirements
- R1: A START followed by address byte 0xD2 (write) or 0xD3 (read) is acknowledged by holding SDA low in the ninth clock. Any other address byte gets no acknowledge, and the rest of that transfer changes no register.
- R2: In a write, the two bytes after the address byte are each acknowledged, and their contents change no register.
- R3: Data bytes after those two go into register 0, then 1, then 2, and so on, each acknowledged. A transfer may stop after any whole byte. Register i appears on cfg_flat[8i+7:8i].
- R4: After a read address, the slave sends register 0 first (MSB first), then the following registers in order, for as long as the master acknowledges. A master NACK ends the read, and the slave releases SDA.
- R5: After reset, register 0 reads 0x00 and registers 1 to 5 read 0xFF. A 1 bit enables a clock output, and a 0 bit holds that output low.
- R6: With oe_pin high, register 0 bits 1:0 select the function. 00 is normal operation, with out_float, test_mode and spread_en all 0. 01 sets test_mode. 10 sets spread_en. 11 sets out_float.
- R7: With oe_pin low, out_float is 1 and test_mode and spread_en are 0, whatever register 0 holds.
- R8: sda_pull changes only while SCL is low.
- R9: Data bytes beyond the last register are acknowledged and ignored. Read bytes beyond the last register are 0xFF.
- R10: A START in the middle of a transfer restarts it at the address byte, and the next data byte again goes into register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the bus bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_pull | output | 1 | 1 asks the pad to pull SDA low |
| oe_pin | input | 1 | Output enable pin, low forces all clocks to float |
| cfg_flat | output | NUM_REGS*8 | Register bank, register i in bits 8i+7:8i |
| out_float | output | 1 | All clock outputs high-impedance |
| test_mode | output | 1 | Clock outputs take divided test-input clocks |
| spread_en | output | 1 | Spread-spectrum modulation enabled |

## Verification
The assertions take for granted a master that keeps SCL and SDA edges at least a few system clocks apart. They also take for granted that SDA moves only while SCL is low, except for deliberate START and STOP conditions, so that the synchronized lines never show a clock edge and a data edge in the same cycle. The bench master splits every bus bit into four phases of ten system clocks each. It changes SDA only in the middle of the low phase, and it never issues START or STOP while the slave is pulling SDA low. Under those conditions the sampler's view of both lines is clean. Any pull-down change seen during SCL high, or any register change without a write strobe, then points at the slave.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RX   = 3'd1,
    ST_ACK  = 3'd2,
    ST_TX   = 3'd3,
    ST_MACK = 3'd4
  } bus_st_t;

  typedef enum logic [1:0] {
    PH_ADDR = 2'd0,
    PH_SKIP = 2'd1,
    PH_DATA = 2'd2
  } rx_ph_t;

  typedef enum logic [1:0] {
    FN_NORMAL = 2'b00,
    FN_TEST   = 2'b01,
    FN_SPREAD = 2'b10,
    FN_FLOAT  = 2'b11
  } fn_sel_t;

  localparam logic [7:0] REG0_RST  = 8'h00;
  localparam logic [7:0] REGN_RST  = 8'hFF;
  localparam logic [7:0] PAST_END  = 8'hFF;
endpackage

// File: rtl/cfg_line_sampler.sv
module cfg_line_sampler #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC-1:0] scl_sh, sda_sh;
  logic            scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC-2:0], scl_in};
      sda_sh <= {sda_sh[SYNC-2:0], sda_in};
      scl_d  <= scl_sh[SYNC-1];
      sda_d  <= sda_sh[SYNC-1];
    end
  end

  assign scl_lvl   = scl_sh[SYNC-1];
  assign sda_lvl   = sda_sh[SYNC-1];
  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  assign start_det = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/cfg_bus_fsm.sv
module cfg_bus_fsm
  import cfg_pkg::*;
#(
  parameter int         NUM_REGS = 6,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         IDX_W    = $clog2(NUM_REGS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_lvl,
  input  logic             sda_lvl,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [7:0]       rd_byte,
  output logic [IDX_W-1:0] rd_idx,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic             sda_pull
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS);

  bus_st_t          st_q, st_d;
  rx_ph_t           ph_q, ph_d;
  logic [2:0]       bit_q, bit_d;
  logic [7:0]       sh_q, sh_d;
  logic             full_q, full_d;
  logic             skip_q, skip_d;
  logic             rd_q, rd_d;
  logic             mack_q, mack_d;
  logic             pull_q, pull_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    full_d = full_q;
    skip_d = skip_q;
    rd_d   = rd_q;
    mack_d = mack_q;
    pull_d = pull_q;
    idx_d  = idx_q;
    wr_en  = 1'b0;
    if (start_det) begin
      st_d   = ST_RX;
      ph_d   = PH_ADDR;
      bit_d  = 3'd0;
      full_d = 1'b0;
      pull_d = 1'b0;
      idx_d  = '0;
    end else if (stop_det) begin
      st_d   = ST_IDLE;
      pull_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_RX: begin
          if (scl_rise && !full_q) begin
            sh_d  = {sh_q[6:0], sda_lvl};
            bit_d = bit_q + 3'd1;
            if (bit_q == 3'd7) full_d = 1'b1;
          end else if (scl_fall && full_q) begin
            full_d = 1'b0;
            unique case (ph_q)
              PH_ADDR: begin
                if (sh_q[7:1] == DEV_ADDR) begin
                  st_d   = ST_ACK;
                  pull_d = 1'b1;
                  rd_d   = sh_q[0];
                  ph_d   = PH_SKIP;
                  skip_d = 1'b0;
                  idx_d  = '0;
                end else begin
                  st_d = ST_IDLE;
                end
              end
              PH_SKIP: begin
                st_d   = ST_ACK;
                pull_d = 1'b1;
                if (skip_q) ph_d = PH_DATA;
                skip_d = 1'b1;
              end
              default: begin
                st_d   = ST_ACK;
                pull_d = 1'b1;
                if (idx_q < LAST_IDX) begin
                  wr_en = 1'b1;
                  idx_d = idx_q + IDX_W'(1);
                end
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (rd_q) begin
              st_d   = ST_TX;
              sh_d   = rd_byte;
              pull_d = ~rd_byte[7];
              bit_d  = 3'd0;
            end else begin
              st_d   = ST_RX;
              pull_d = 1'b0;
              bit_d  = 3'd0;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_q == 3'd7) begin
              st_d   = ST_MACK;
              pull_d = 1'b0;
              bit_d  = 3'd0;
              mack_d = 1'b0;
              if (idx_q < LAST_IDX) idx_d = idx_q + IDX_W'(1);
            end else begin
              sh_d   = {sh_q[6:0], 1'b1};
              pull_d = ~sh_q[6];
              bit_d  = bit_q + 3'd1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_d = ~sda_lvl;
          end else if (scl_fall) begin
            if (mack_q) begin
              st_d   = ST_TX;
              sh_d   = rd_byte;
              pull_d = ~rd_byte[7];
              bit_d  = 3'd0;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= PH_ADDR;
      bit_q  <= 3'd0;
      sh_q   <= 8'h00;
      full_q <= 1'b0;
      skip_q <= 1'b0;
      rd_q   <= 1'b0;
      mack_q <= 1'b0;
      pull_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      full_q <= full_d;
      skip_q <= skip_d;
      rd_q   <= rd_d;
      mack_q <= mack_d;
      pull_q <= pull_d;
      idx_q  <= idx_d;
    end
  end

  assign rd_idx   = idx_q;
  assign wr_idx   = idx_q;
  assign wr_data  = sh_q;
  assign sda_pull = pull_q;

  // R8: the pull-down only moves while the synchronized SCL is low
  a_r8_pull_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pull_q) |-> !scl_lvl);

  // R1: SDA is only grabbed right after a detected SCL falling edge
  a_r1_pull_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_q) |-> $past(scl_fall));

  // R9: the byte pointer saturates one past the last register
  a_r9_idx_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST_IDX);
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_pkg::*;
#(
  parameter int NUM_REGS = 6,
  parameter int IDX_W    = $clog2(NUM_REGS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] regs_flat
);
  logic [7:0] regs_q [NUM_REGS];
  logic [7:0] regs_d [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [7:0] RST_VAL = (i == 0) ? REG0_RST : REGN_RST;
    logic hit;
    assign hit       = wr_en && (wr_idx == IDX_W'(i));
    assign regs_d[i] = hit ? wr_data : regs_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_q[i] <= RST_VAL;
      else        regs_q[i] <= regs_d[i];
    end

    assign regs_flat[i*8 +: 8] = regs_q[i];

    // R3: a register changes only under a strobe aimed at its own index
    a_r3_change_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(regs_q[i]) |-> ($past(wr_en) && ($past(wr_idx) == IDX_W'(i))));
  end

  always_comb begin
    rd_data = PAST_END;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (rd_idx == IDX_W'(k)) rd_data = regs_q[k];
    end
  end
endmodule

// File: rtl/clkcfg_serial_slave.sv
module clkcfg_serial_slave
  import cfg_pkg::*;
#(
  parameter int         NUM_REGS    = 6,
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_in,
  input  logic                  sda_in,
  output logic                  sda_pull,
  input  logic                  oe_pin,
  output logic [NUM_REGS*8-1:0] cfg_flat,
  output logic                  out_float,
  output logic                  test_mode,
  output logic                  spread_en
);
  localparam int IDX_W = $clog2(NUM_REGS + 1);

  logic [1:0] rst_sh;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= 2'b00;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_core_n = rst_sh[1];

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [7:0]       wr_data, rd_byte;

  cfg_line_sampler #(.SYNC(SYNC_STAGES)) u_sampler (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  cfg_bus_fsm #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR), .IDX_W(IDX_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_byte   (rd_byte),
    .rd_idx    (rd_idx),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .sda_pull  (sda_pull)
  );

  cfg_reg_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .rd_idx    (rd_idx),
    .rd_data   (rd_byte),
    .regs_flat (cfg_flat)
  );

  fn_sel_t fn;
  assign fn        = fn_sel_t'(cfg_flat[1:0]);
  assign out_float = !oe_pin || (fn == FN_FLOAT);
  assign test_mode = oe_pin && (fn == FN_TEST);
  assign spread_en = oe_pin && (fn == FN_SPREAD);
endmodule

// File: tb/clkcfg_serial_slave_test.sv
`timescale 1ns/1ps
module clkcfg_serial_slave_test;
  localparam int NREG = 6;
  localparam int Q    = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic oe = 1'b1;
  logic sda_pull;
  logic sda_line;
  logic [NREG*8-1:0] cfg_flat;
  logic out_float, test_mode, spread_en;

  int checks = 0;
  int errors = 0;
  int viol = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign sda_line = m_sda & ~sda_pull;

  clkcfg_serial_slave uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl),
    .sda_in    (sda_line),
    .sda_pull  (sda_pull),
    .oe_pin    (oe),
    .cfg_flat  (cfg_flat),
    .out_float (out_float),
    .test_mode (test_mode),
    .spread_en (spread_en)
  );

  // {oe, reg0[1:0], out_float, test_mode, spread_en}
  localparam logic [5:0] VEC [8] = '{
    6'b1_00_000, 6'b1_01_010, 6'b1_10_001, 6'b1_11_100,
    6'b0_00_100, 6'b0_01_100, 6'b0_10_100, 6'b0_11_100
  };

  // R8 monitor: pull-down may change only while SCL is low
  logic pull_prev = 1'b0;
  logic scl_prev  = 1'b1;
  always @(negedge clk) begin
    #1;
    if (rst_n && (sda_pull !== pull_prev) && (scl || scl_prev)) viol++;
    pull_prev = sda_pull;
    scl_prev  = scl;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; wq(Q);
    scl = 1'b1; wq(Q);
    m_sda = 1'b0; wq(Q);
    scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; wq(Q);
    scl = 1'b1; wq(Q);
    m_sda = 1'b1; wq(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      wq(Q); m_sda = b[i];
      wq(Q); scl = 1'b1;
      wq(2*Q); scl = 1'b0;
    end
    wq(Q); m_sda = 1'b1;
    wq(Q); scl = 1'b1;
    wq(Q); acked = ~sda_line;
    wq(Q); scl = 1'b0;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      wq(Q); m_sda = 1'b1;
      wq(Q); scl = 1'b1;
      wq(Q); b[i] = sda_line;
      wq(Q); scl = 1'b0;
    end
    wq(Q); m_sda = ~give_ack;
    wq(Q); scl = 1'b1;
    wq(2*Q); scl = 1'b0;
    wq(Q); m_sda = 1'b1;
  endtask

  task automatic write_reg0(input logic [7:0] v);
    logic a;
    bus_start;
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    send_byte(8'h00, a);
    send_byte(v, a);
    bus_stop;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run;
  end

  initial begin
    logic a;
    logic [7:0] rb;
    logic [7:0] acks;
    wq(8);
    rst_n = 1'b1;
    wq(10);

    // R5: reset contents
    chk("R5 reset bank", 64'(cfg_flat), 64'h0000_FFFF_FFFF_FF00);
    chk("R8 idle pull", 64'(sda_pull), 64'h0);
    chk("R6 reset flags", 64'({out_float, test_mode, spread_en}), 64'h0);

    // R6 / R7: function select table
    for (int k = 0; k < 8; k++) begin
      oe = VEC[k][5];
      write_reg0({6'b0, VEC[k][4:3]});
      wq(4);
      chk(VEC[k][5] ? "R6 function decode" : "R7 oe override",
          64'({out_float, test_mode, spread_en}), 64'(VEC[k][2:0]));
    end
    oe = 1'b1;
    write_reg0(8'h00);

    // R1: foreign address gets no ack and changes nothing
    bus_start;
    send_byte(8'hA0, a);
    chk("R1 foreign address nack", 64'(a), 64'h0);
    send_byte(8'h00, a);
    send_byte(8'h00, a);
    send_byte(8'h5A, a);
    bus_stop;
    chk("R1 foreign transfer no effect", 64'(cfg_flat), 64'h0000_FFFF_FFFF_FF00);

    // R2 / R3: skipped bytes, partial write
    bus_start;
    send_byte(8'hD2, a);
    chk("R1 write address ack", 64'(a), 64'h1);
    send_byte(8'h55, a);
    chk("R2 command byte ack", 64'(a), 64'h1);
    send_byte(8'hAA, a);
    chk("R2 count byte ack", 64'(a), 64'h1);
    chk("R2 skipped bytes discarded", 64'(cfg_flat), 64'h0000_FFFF_FFFF_FF00);
    send_byte(8'h00, a);
    send_byte(8'h12, a);
    send_byte(8'h34, a);
    chk("R3 data byte ack", 64'(a), 64'h1);
    bus_stop;
    chk("R3 partial sequential write", 64'(cfg_flat), 64'h0000_FFFF_FF34_1200);

    // R9: write past the end
    bus_start;
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    send_byte(8'h00, a);
    for (int i = 0; i < 8; i++) begin
      send_byte(8'hA0 + 8'(i), a);
      acks[i] = a;
    end
    bus_stop;
    chk("R9 extra bytes acked", 64'(acks), 64'hFF);
    chk("R9 full bank write", 64'(cfg_flat), 64'h0000_A5A4_A3A2_A1A0);

    // R4 / R9: readback from register 0, past the end gives FF
    bus_start;
    send_byte(8'hD3, a);
    chk("R1 read address ack", 64'(a), 64'h1);
    for (int i = 0; i < 7; i++) begin
      recv_byte(i < 6, rb);
      if (i < 6) chk("R4 readback order", 64'(rb), 64'(8'hA0 + 8'(i)));
      else       chk("R9 read past end", 64'(rb), 64'hFF);
    end
    wq(Q);
    chk("R4 released after nack", 64'(sda_pull), 64'h0);
    bus_stop;
    chk("R4 read leaves bank", 64'(cfg_flat), 64'h0000_A5A4_A3A2_A1A0);

    // R10: repeated start restarts at register 0
    bus_start;
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    send_byte(8'h00, a);
    send_byte(8'h11, a);
    bus_start;
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    send_byte(8'h00, a);
    send_byte(8'h22, a);
    bus_stop;
    chk("R10 restart at register 0", 64'(cfg_flat), 64'h0000_A5A4_A3A2_A122);

    // R5: reset in mid-run restores defaults
    rst_n = 1'b0;
    wq(4);
    rst_n = 1'b1;
    wq(10);
    chk("R5 reset restores bank", 64'(cfg_flat), 64'h0000_FFFF_FFFF_FF00);

    chk("R8 pull moved only with SCL low", 64'(viol), 64'h0);
    finish_run;
  end
endmodule